// File: doc/BRIEF.md
# AC97 Slot Tag Framer

This block is the framing layer between a pair of sample FIFOs and a 13-slot AC97 serial engine. On the transmit side it decides, once per frame, whether the frame can carry data. When it can, it builds the slot 0 tag word from a mask of data slots 3 to 12. It then pulls exactly those slots' words out of the transmit FIFO as the serializer asks for them. The command slots 1 and 2 always go out idle. Only data slots ever pass through the FIFOs.

On the receive side the serializer hands over each received slot as a parallel word. The block reads the tags in slot 0 and compares the data-slot tags against an expected mask. When they agree, it writes only the expected slots to the receive FIFO, lowest slot first, so the FIFO order alone identifies each slot. When they disagree, it drops every data slot of that frame and sets a sticky status flag. Software clears that flag with a write-one strobe.

The serial timing, the bit clock and the FIFOs themselves live outside this block. Mask bit k (k = 0..9) always stands for slot 3+k.

Top module: `ac97_slot_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_slot_vld`, `rx_push`, `unexp_flag` and `tx_pop` are 0.
- R2: In a data frame, the slot 0 word carries the 16-bit tag in its top 16 bits with the lower bits zero. Tag bit 15 (frame valid) is 1 and tag bits 14 and 13 (command tags) are 0. Tag bit 12-k equals `tx_mask[k]`, and tag bits 2..0 are 0.
- R3: The send decision is taken in the cycle `frame_start` is high. The frame carries data only if `codec_ready` is 1 and `tx_level` is at least the number of ones in `tx_mask`. Otherwise the whole slot 0 word is zero and no word is popped in that frame.
- R4: Requests for slots 1 and 2 always return an all-zero word and never pop the FIFO.
- R5: In a data frame, a request for a selected data slot asserts `tx_pop` in the request cycle, and the popped FIFO head is returned as the slot word. A request for an unselected slot returns zero and does not pop.
- R6: A received frame whose slot 0 has frame valid set and data tags equal to `rx_mask` (sampled with slot 0) writes each expected slot's word to the receive FIFO, in ascending slot order, one cycle after it arrives. The command tag bits take no part in the comparison.
- R7: A received frame with frame valid set and data tags different from `rx_mask` writes nothing to the receive FIFO and sets `unexp_flag`.
- R8: `unexp_flag` stays set across later good frames until a cycle with `unexp_clr` high. A mismatch in the same cycle as `unexp_clr` leaves the flag set.
- R9: A received frame with frame valid clear writes nothing and leaves `unexp_flag` unchanged.
- R10: `tx_slot_vld` and `tx_slot_word` answer a request one cycle after `tx_slot_req`. `tx_slot_vld` is low in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each transmit frame |
| codec_ready | input | 1 | Codec-ready seen in the current frame |
| tx_mask | input | 10 | Data slots to send; bit k is slot 3+k |
| rx_mask | input | 10 | Data slots expected on receive; bit k is slot 3+k |
| tx_slot_req | input | 1 | Serializer asks for the word of one slot |
| tx_slot_idx | input | 4 | Slot number requested, 0..12 |
| tx_slot_word | output | 20 | Slot word for the serializer |
| tx_slot_vld | output | 1 | `tx_slot_word` answers the previous cycle's request |
| tx_level | input | 6 | Words held in the transmit FIFO |
| tx_fifo_data | input | 20 | Head word of the transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Consume the transmit FIFO head |
| rx_slot_vld | input | 1 | A received slot word is present |
| rx_slot_idx | input | 4 | Slot number of the received word, 0..12 |
| rx_slot_word | input | 20 | Received slot word |
| rx_push | output | 1 | Write `rx_push_data` into the receive FIFO |
| rx_push_data | output | 20 | Data word for the receive FIFO |
| unexp_flag | output | 1 | Sticky flag: received tags differed from `rx_mask` |
| unexp_clr | input | 1 | Write-one strobe that clears `unexp_flag` |

## Verification
The embedded properties assume several things about the serializer. `frame_start` never coincides with a slot request. Slot 0 of a frame is requested and received before any of its data slots. No request asks for more pops than the latched mask allows. The receive stream arrives one slot per cycle with indices 0 to 12 in order. The bench drives each frame as a frame-start pulse followed by thirteen back-to-back requests, and feeds the receive side complete frames in slot order. It also keeps the transmit FIFO model's head stable between pops, so the forwarding and pop-budget properties see the traffic they were written for.

// File: rtl/ac97_tag_pkg.sv
package ac97_tag_pkg;

    localparam int NUM_DATA   = 10;
    localparam int FIRST_DATA = 3;
    localparam int LAST_SLOT  = FIRST_DATA + NUM_DATA - 1;
    localparam int TAG_W      = 16;
    localparam int IDX_W      = 4;

    typedef logic [NUM_DATA-1:0] slot_mask_t;
    typedef logic [IDX_W-1:0]    slot_idx_t;

    // Slot 0 tag layout, most significant field first
    typedef struct packed {
        logic                frame_ok;
        logic                cmd_addr_tag;
        logic                cmd_data_tag;
        logic [NUM_DATA-1:0] data_tags;
        logic [2:0]          pad;
    } tag_word_t;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_DATA  = 2'd1,
        FR_EMPTY = 2'd2
    } tx_frame_e;

    // Mask bit k (slot 3+k) lands in data_tags[NUM_DATA-1-k]
    function automatic logic [NUM_DATA-1:0] mask_to_tags(input slot_mask_t m);
        logic [NUM_DATA-1:0] t;
        for (int k = 0; k < NUM_DATA; k++) begin
            t[NUM_DATA-1-k] = m[k];
        end
        return t;
    endfunction

    function automatic slot_mask_t tags_to_mask(input logic [NUM_DATA-1:0] t);
        slot_mask_t m;
        for (int k = 0; k < NUM_DATA; k++) begin
            m[k] = t[NUM_DATA-1-k];
        end
        return m;
    endfunction

    function automatic slot_idx_t mask_count(input slot_mask_t m);
        slot_idx_t c;
        c = '0;
        for (int k = 0; k < NUM_DATA; k++) begin
            c = c + slot_idx_t'(m[k]);
        end
        return c;
    endfunction

    // True when idx is a data slot selected by m
    function automatic logic mask_hit(input slot_mask_t m, input slot_idx_t idx);
        logic h;
        h = 1'b0;
        for (int k = 0; k < NUM_DATA; k++) begin
            if (idx == slot_idx_t'(k + FIRST_DATA)) begin
                h = m[k];
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/ac97_tx_tagger.sv
module ac97_tx_tagger
    import ac97_tag_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              codec_ready,
    input  slot_mask_t        tx_mask,
    input  logic              slot_req,
    input  slot_idx_t         slot_idx,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [SLOT_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic [SLOT_W-1:0] slot_word,
    output logic              slot_vld
);

    tx_frame_e         mode_q;
    slot_mask_t        mask_q;
    logic [LVL_W-1:0]  need_lvl;
    logic              can_send;
    tag_word_t         tag_now;
    logic              hit;
    logic [SLOT_W-1:0] word_d;
    logic [SLOT_W-1:0] word_q;
    logic              vld_q;
    slot_idx_t         pop_cnt;

    // Send decision, taken once per frame
    always_comb begin
        need_lvl = LVL_W'(mask_count(tx_mask));
        can_send = codec_ready && (fifo_level >= need_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= FR_IDLE;
            mask_q <= '0;
        end else if (frame_start) begin
            mode_q <= can_send ? FR_DATA : FR_EMPTY;
            mask_q <= tx_mask;
        end
    end

    // Slot 0 tag: command tags stay clear, empty frames carry all zeros
    always_comb begin
        tag_now = '0;
        if (mode_q == FR_DATA) begin
            tag_now.frame_ok  = 1'b1;
            tag_now.data_tags = mask_to_tags(mask_q);
        end
    end

    always_comb begin
        hit      = mask_hit(mask_q, slot_idx);
        fifo_pop = slot_req && (mode_q == FR_DATA) && hit;
        word_d   = '0;
        if (slot_idx == '0) begin
            word_d[SLOT_W-1 -: TAG_W] = tag_now;
        end else if (fifo_pop) begin
            word_d = fifo_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= slot_req;
            if (slot_req) begin
                word_q <= word_d;
            end
        end
    end

    assign slot_word = word_q;
    assign slot_vld  = vld_q;

    // Pops taken in the current frame, for the budget check
    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            pop_cnt <= '0;
        end else if (fifo_pop) begin
            pop_cnt <= pop_cnt + 1'b1;
        end
    end

    // R3
    empty_frame_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !codec_ready) |=> !fifo_pop);

    // R4
    cmd_slot_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_req && (slot_idx == 4'd1 || slot_idx == 4'd2)) |=> (slot_word == '0));

    // R5
    pop_budget_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (pop_cnt < mask_count(mask_q)));

    // R5
    data_forward_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (slot_word == $past(fifo_data)));

    // R10
    word_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> $past(slot_req));

endmodule

// File: rtl/ac97_rx_checker.sv
module ac97_rx_checker
    import ac97_tag_pkg::*;
#(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  slot_idx_t         rx_idx,
    input  logic [SLOT_W-1:0] rx_word,
    input  slot_mask_t        rx_mask,
    input  logic              flag_clr,
    output logic              push,
    output logic [SLOT_W-1:0] push_data,
    output logic              unexp_flag
);

    localparam int TAG_TOP  = SLOT_W - 1;
    localparam int DATA_TOP = TAG_TOP - 3;

    logic              accept_q;
    slot_mask_t        exp_q;
    logic              flag_q;
    logic              push_q;
    logic [SLOT_W-1:0] data_q;
    logic              tag_evt;
    logic              frame_ok;
    logic              tag_match;
    logic              bad_evt;
    logic              take;

    always_comb begin
        tag_evt   = rx_vld && (rx_idx == '0);
        frame_ok  = rx_word[TAG_TOP];
        tag_match = (tags_to_mask(rx_word[DATA_TOP -: NUM_DATA]) == rx_mask);
        bad_evt   = tag_evt && frame_ok && !tag_match;
        take      = rx_vld && accept_q && mask_hit(exp_q, rx_idx);
    end

    // Frame verdict, refreshed at every slot 0
    always_ff @(posedge clk) begin
        if (rst) begin
            accept_q <= 1'b0;
            exp_q    <= '0;
        end else if (tag_evt) begin
            accept_q <= frame_ok && tag_match;
            exp_q    <= rx_mask;
        end
    end

    // Sticky status: a new mismatch wins over the clear strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (bad_evt) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_q <= 1'b0;
            data_q <= '0;
        end else begin
            push_q <= take;
            if (take) begin
                data_q <= rx_word;
            end
        end
    end

    assign push       = push_q;
    assign push_data  = data_q;
    assign unexp_flag = flag_q;

    // R6
    push_from_data_slot_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> ($past(rx_vld) && $past(rx_idx) >= 4'd3 && $past(rx_idx) <= 4'd12));

    // R7
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unexp_flag) |-> !accept_q);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !rx_vld) |=> !unexp_flag);

    // R9
    invalid_frame_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && rx_idx == '0 && !rx_word[TAG_TOP] && !flag_clr) |=> $stable(unexp_flag));

endmodule

// File: rtl/ac97_slot_framer.sv
module ac97_slot_framer
    import ac97_tag_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              codec_ready,
    input  logic [9:0]        tx_mask,
    input  logic [9:0]        rx_mask,
    input  logic              tx_slot_req,
    input  logic [3:0]        tx_slot_idx,
    output logic [SLOT_W-1:0] tx_slot_word,
    output logic              tx_slot_vld,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [SLOT_W-1:0] tx_fifo_data,
    output logic              tx_pop,
    input  logic              rx_slot_vld,
    input  logic [3:0]        rx_slot_idx,
    input  logic [SLOT_W-1:0] rx_slot_word,
    output logic              rx_push,
    output logic [SLOT_W-1:0] rx_push_data,
    output logic              unexp_flag,
    input  logic              unexp_clr
);

    ac97_tx_tagger #(
        .SLOT_W (SLOT_W),
        .LVL_W  (LVL_W)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .codec_ready (codec_ready),
        .tx_mask     (tx_mask),
        .slot_req    (tx_slot_req),
        .slot_idx    (tx_slot_idx),
        .fifo_level  (tx_level),
        .fifo_data   (tx_fifo_data),
        .fifo_pop    (tx_pop),
        .slot_word   (tx_slot_word),
        .slot_vld    (tx_slot_vld)
    );

    ac97_rx_checker #(
        .SLOT_W (SLOT_W)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_vld     (rx_slot_vld),
        .rx_idx     (rx_slot_idx),
        .rx_word    (rx_slot_word),
        .rx_mask    (rx_mask),
        .flag_clr   (unexp_clr),
        .push       (rx_push),
        .push_data  (rx_push_data),
        .unexp_flag (unexp_flag)
    );

endmodule

// File: tb/sim_ac97_slot_framer.sv
module sim_ac97_slot_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        codec_ready = 1'b0;
    logic [9:0]  tx_mask = '0;
    logic [9:0]  rx_mask = '0;
    logic        tx_slot_req = 1'b0;
    logic [3:0]  tx_slot_idx = '0;
    logic [19:0] tx_slot_word;
    logic        tx_slot_vld;
    logic [5:0]  tx_level;
    logic [19:0] tx_fifo_data;
    logic        tx_pop;
    logic        rx_slot_vld = 1'b0;
    logic [3:0]  rx_slot_idx = '0;
    logic [19:0] rx_slot_word = '0;
    logic        rx_push;
    logic [19:0] rx_push_data;
    logic        unexp_flag;
    logic        unexp_clr = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int fnum   = 0;

    // Transmit FIFO model (show-ahead)
    logic [19:0] fmem [0:31];
    int wr = 0;
    int rd = 0;
    int exp_rd = 0;
    assign tx_level     = 6'(wr - rd);
    assign tx_fifo_data = fmem[rd[4:0]];

    // Receive FIFO capture
    logic [19:0] got [0:63];
    int n_got = 0;

    always #2.5 clk = ~clk;

    ac97_slot_framer #(.SLOT_W(20), .LVL_W(6)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .codec_ready(codec_ready),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .tx_slot_req(tx_slot_req),
        .tx_slot_idx(tx_slot_idx), .tx_slot_word(tx_slot_word), .tx_slot_vld(tx_slot_vld),
        .tx_level(tx_level), .tx_fifo_data(tx_fifo_data), .tx_pop(tx_pop),
        .rx_slot_vld(rx_slot_vld), .rx_slot_idx(rx_slot_idx), .rx_slot_word(rx_slot_word),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .unexp_flag(unexp_flag),
        .unexp_clr(unexp_clr)
    );

    always @(posedge clk) begin
        if (tx_pop) rd <= rd + 1;
        if (rx_push) begin
            got[n_got[5:0]] <= rx_push_data;
            n_got <= n_got + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Tag built from the requirement text: bit 15 valid, bit 12-k for mask bit k
    function automatic logic [15:0] btag(input logic fv, input logic [9:0] m);
        logic [15:0] t;
        t = '0;
        t[15] = fv;
        for (int k = 0; k < 10; k++) t[12-k] = m[k];
        return t;
    endfunction

    task automatic check_reset();
        @(negedge clk);
        chk("R1", tx_slot_vld, 0, "slot valid in reset");
        chk("R1", rx_push, 0, "push in reset");
        chk("R1", unexp_flag, 0, "flag in reset");
        chk("R1", tx_pop, 0, "pop in reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R1", tx_slot_vld, 0, "slot valid after reset");
        chk("R1", unexp_flag, 0, "flag after reset");
    endtask

    task automatic tx_frame(input logic cr, input logic [9:0] mask, input int add,
                            input string name);
        logic        send;
        logic        exp_pop;
        logic [19:0] exp_w;
        string       wlab;
        for (int i = 0; i < add; i++) begin
            fmem[wr[4:0]] = 20'hC0000 + 20'(wr);
            wr++;
        end
        send = cr && ((wr - rd) >= $countones(mask));
        @(negedge clk);
        codec_ready = cr;
        tx_mask     = mask;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        exp_w = '0;
        wlab  = "R2";
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk("R10", tx_slot_vld, 1, {name, " slot valid"});
                chk(wlab, tx_slot_word, exp_w, {name, " slot word"});
            end
            tx_slot_req = 1'b1;
            tx_slot_idx = 4'(k);
            exp_pop = send && (k >= 3) && mask[k-3];
            if (k == 0) begin
                exp_w = send ? {btag(1'b1, mask), 4'h0} : 20'h0;
                wlab  = send ? "R2" : "R3";
            end else if (k < 3) begin
                exp_w = '0;
                wlab  = "R4";
            end else begin
                exp_w = exp_pop ? fmem[exp_rd[4:0]] : 20'h0;
                wlab  = send ? "R5" : "R3";
            end
            #1;
            chk(send ? "R5" : "R3", tx_pop, exp_pop, {name, " pop"});
            if (exp_pop) exp_rd++;
        end
        @(negedge clk);
        chk("R10", tx_slot_vld, 1, {name, " last slot valid"});
        chk(wlab, tx_slot_word, exp_w, {name, " last slot word"});
        tx_slot_req = 1'b0;
        @(negedge clk);
        chk("R10", tx_slot_vld, 0, {name, " idle valid"});
        chk("R5", rd, exp_rd, {name, " words consumed"});
    endtask

    task automatic rx_frame(input logic fv, input logic [9:0] tagm, input logic [1:0] cmdt,
                            input logic [9:0] expm, input logic clr_at_tag,
                            input logic exp_flag, input string req, input string name);
        int          start;
        int          n_exp;
        int          j;
        logic        accept;
        logic [15:0] t;
        start  = n_got;
        fnum++;
        accept = fv && (tagm == expm);
        t      = btag(fv, tagm);
        t[14]  = cmdt[1];
        t[13]  = cmdt[0];
        @(negedge clk);
        rx_mask      = expm;
        rx_slot_vld  = 1'b1;
        rx_slot_idx  = 4'd0;
        rx_slot_word = {t, 4'h0};
        unexp_clr    = clr_at_tag;
        for (int k = 1; k < 13; k++) begin
            @(negedge clk);
            unexp_clr    = 1'b0;
            rx_slot_idx  = 4'(k);
            rx_slot_word = 20'h50000 | 20'(fnum << 8) | 20'(k);
        end
        @(negedge clk);
        rx_slot_vld = 1'b0;
        @(negedge clk);
        n_exp = accept ? $countones(expm) : 0;
        chk(req, n_got - start, n_exp, {name, " push count"});
        j = 0;
        for (int k = 0; k < 10; k++) begin
            if (accept && expm[k]) begin
                chk("R6", got[(start + j) % 64],
                    20'h50000 | 20'(fnum << 8) | 20'(k + 3), {name, " pushed word"});
                j++;
            end
        end
        chk(req, unexp_flag, exp_flag, {name, " flag"});
    endtask

    task automatic clear_flag();
        @(negedge clk);
        unexp_clr = 1'b1;
        @(negedge clk);
        unexp_clr = 1'b0;
        chk("R8", unexp_flag, 0, "flag after clear strobe");
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        check_reset();
        // R2 R5: two slots at the mask ends, level exactly enough
        tx_frame(1'b1, 10'h201, 2, "tx_ends");
        // R3: one word short of the mask
        tx_frame(1'b1, 10'h0F0, 3, "tx_short");
        // R3 boundary: level equals the count
        tx_frame(1'b1, 10'h0F0, 1, "tx_exact");
        // R3: codec not ready although the FIFO is full enough
        tx_frame(1'b0, 10'h3FF, 10, "tx_notready");
        // R2 R4 R5: all data slots
        tx_frame(1'b1, 10'h3FF, 0, "tx_all");

        // R6: match, command tags set but ignored
        rx_frame(1'b1, 10'h005, 2'b11, 10'h005, 1'b0, 1'b0, "R6", "rx_match");
        // R7: mismatch drops the frame and flags
        rx_frame(1'b1, 10'h006, 2'b00, 10'h005, 1'b0, 1'b1, "R7", "rx_mismatch");
        // R8: good frame leaves the sticky flag set
        rx_frame(1'b1, 10'h3FF, 2'b00, 10'h3FF, 1'b0, 1'b1, "R8", "rx_sticky");
        clear_flag();
        // R9: invalid frame, no push, flag untouched
        rx_frame(1'b0, 10'h000, 2'b00, 10'h001, 1'b0, 1'b0, "R9", "rx_invalid");
        // R6 boundary: empty expected mask and empty tags
        rx_frame(1'b1, 10'h000, 2'b00, 10'h000, 1'b0, 1'b0, "R6", "rx_nodata");
        // R8: mismatch in the same cycle as the clear strobe
        rx_frame(1'b1, 10'h100, 2'b00, 10'h001, 1'b1, 1'b1, "R8", "rx_setwins");
        // R6: single top slot accepted while flag stays set
        rx_frame(1'b1, 10'h200, 2'b00, 10'h200, 1'b0, 1'b1, "R6", "rx_top");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule